// File: doc/BRIEF.md
# Power-Fail Auxiliary Control Registers

This block is a small bank of control and status registers reached over a single-cycle memory-mapped bus. Each register has its own select line and accepts one access width only: byte for most registers, half-word for the LED register, word for the system-control register. Several writes have side effects. One write fires a floppy terminal-count strobe. Another requests a system shutdown. A third requests a system reset.

A power-failing input is synchronised into the clock domain. A change of its level updates a sticky power-fail status bit, but only sets that bit while an enable bit in the configuration register is on. The interrupt output is raised while the status bit and the enable bit are both set. Software clears the status by writing a self-clearing bit in the power register.

A block reset clears the configuration, function, power and modem registers. The diagnostic, LED and system-control registers keep their contents across the reset, so software can still read them afterwards.

Top module: `pwrfail_aux_regs`

## Requirements
- R1: `pf_irq` is high exactly when power register bit 5 (status) and configuration register bit 3 (enable) are both 1. Clearing the enable bit drops the interrupt but leaves the status bit set.
- R2: `pwr_fail_in` passes through two synchroniser flops. A change of the synchronised level updates status bit 5 on the following edge, so a level driven before edge k takes effect at edge k+2. A rise sets bit 5 to the value of enable bit 3. A fall clears bit 5. While the level is steady, bit 5 does not change except through writes.
- R3: A power-register write keeps only data bits 0 (power-off) and 1 (clear) and preserves the current bit 5. If bit 1 is written as 1, the stored value is reduced to bit 0 alone, which clears bit 5. Bit 1 therefore always reads 0.
- R4: When a power-register write stores bit 0 as 1, `shutdown_req` is high for exactly the one cycle after that write's clock edge.
- R5: A function-register write with data bit 1 set makes `tc_pulse` high for the one cycle after the write's edge. Bit 1 is stored as 0. All other bits are stored as written.
- R6: A word write at offset 0 of the system-control register with data bit 0 set loads that register with 0x02 and makes `reset_req` high for one cycle. If data bit 0 is clear, the register is left unchanged.
- R7: Reset clears the configuration, function, power and modem registers and all pulse outputs. The diagnostic, LED and system-control registers keep their values.
- R8: Size codes are 0 for byte, 1 for half-word, 2 for word and 3 for none. An access whose size differs from the register's width is ignored on write and reads as zero. The LED and system-control registers respond only at offset 0; at any other offset they read zero and ignore writes.
- R9: Select bits are 0 configuration, 1 function, 2 power, 3 diagnostic, 4 modem, 5 LED and 6 system control. The diagnostic and modem registers (8 bits) and the LED register (16 bits) read back what was last legally written, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_in | input | 1 | Asynchronous power-failing level |
| bus_sel | input | 7 | One-hot register select |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_size | input | 2 | Access width code |
| bus_off | input | 2 | Byte offset inside the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no legal read |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The power-fail path is driven through several input patterns. A rise with the enable on must set the status. A rise with the enable off must leave it clear. A clear write while the input stays high shows that the status is sticky to events and not to levels. Dropping the enable afterwards separates the interrupt gating from the stored status. Power-register writes with each combination of the power-off and clear bits separate keeping the status from dropping it. Mismatched sizes, non-zero offsets and a reset taken with every register loaded show which registers a reset spares and which accesses are ignored.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    localparam int NREG = 7;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_FUNC = 3'd1,
        RG_PWR  = 3'd2,
        RG_SCR  = 3'd3,
        RG_MDM  = 3'd4,
        RG_LED  = 3'd5,
        RG_SYS  = 3'd6
    } reg_id_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    localparam int CFG_EN_BIT   = 3;
    localparam int FUNC_TC_BIT  = 1;
    localparam int PWR_OFF_BIT  = 0;
    localparam int PWR_CLR_BIT  = 1;
    localparam int PWR_STAT_BIT = 5;
    localparam int SYS_GO_BIT   = 0;
    localparam logic [7:0] SYS_RST_STATUS = 8'h02;

    function automatic logic [1:0] reg_size(int idx);
        if (idx == int'(RG_LED)) return SZ_HALF;
        if (idx == int'(RG_SYS)) return SZ_WORD;
        return SZ_BYTE;
    endfunction

    function automatic bit reg_off0_only(int idx);
        return (idx == int'(RG_LED)) || (idx == int'(RG_SYS));
    endfunction

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] func;
        logic [7:0] pwr;
        logic [7:0] mdm;
        logic       pf_prev;
        logic       tc;
        logic       sd;
        logic       rr;
    } rst_state_t;

    typedef struct packed {
        logic [7:0]  scr;
        logic [7:0]  sys;
        logic [15:0] led;
    } keep_state_t;
endpackage

// File: rtl/pfa_sync.sv
module pfa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pfa_decode.sv
module pfa_decode
    import pfa_pkg::*;
#(
    parameter int N     = NREG,
    parameter int OFF_W = 2
) (
    input  logic [N-1:0]     sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic [N-1:0]     wr_hit,
    output logic [N-1:0]     rd_hit
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam logic [1:0] REG_SZ = reg_size(i);
        localparam bit         OFF0   = reg_off0_only(i);
        logic ok;
        if (OFF0) begin : g_off
            assign ok = sel[i] && (size == REG_SZ) && (off == '0);
        end else begin : g_any
            assign ok = sel[i] && (size == REG_SZ);
        end
        assign wr_hit[i] = wr && ok;
        assign rd_hit[i] = rd && ok;
    end
endmodule

// File: rtl/pfa_rdmux.sv
module pfa_rdmux #(
    parameter int N = 7,
    parameter int W = 32
) (
    input  logic [N-1:0]        hit,
    input  logic [N-1:0][W-1:0] vals,
    output logic [W-1:0]        rdata
);
    logic [N:0][W-1:0] acc;
    assign acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign acc[i+1] = acc[i] | (hit[i] ? vals[i] : '0);
    end
    assign rdata = acc[N];
endmodule

// File: rtl/pwrfail_aux_regs.sv
module pwrfail_aux_regs
    import pfa_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OFF_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail_in,
    input  logic [NREG-1:0]   bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pf_irq,
    output logic              tc_pulse,
    output logic              shutdown_req,
    output logic              reset_req
);
    rst_state_t  rst_d, rst_q;
    keep_state_t keep_d, keep_q;

    logic            pf_s;
    logic [NREG-1:0] wr_hit, rd_hit;
    logic [NREG-1:0][DATA_W-1:0] rd_vals;
    logic [7:0]      pwr_v;
    logic            cfg_en_w;
    logic [7:0]      sys_view;

    pfa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pwr_fail_in), .q(pf_s)
    );

    pfa_decode #(.N(NREG), .OFF_W(OFF_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .rd(bus_rd), .size(bus_size),
        .off(bus_off), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    always_comb begin
        rst_d  = rst_q;
        keep_d = keep_q;
        pwr_v  = '0;
        rst_d.tc = 1'b0;
        rst_d.sd = 1'b0;
        rst_d.rr = 1'b0;
        rst_d.pf_prev = pf_s;

        if (wr_hit[RG_CFG]) rst_d.cfg = bus_wdata[7:0];
        if (wr_hit[RG_MDM]) rst_d.mdm = bus_wdata[7:0];
        if (wr_hit[RG_SCR]) keep_d.scr = bus_wdata[7:0];
        if (wr_hit[RG_LED]) keep_d.led = bus_wdata[15:0];

        if (wr_hit[RG_FUNC]) begin
            rst_d.func = bus_wdata[7:0];
            rst_d.func[FUNC_TC_BIT] = 1'b0;
            rst_d.tc = bus_wdata[FUNC_TC_BIT];
        end

        if (wr_hit[RG_PWR]) begin
            pwr_v[PWR_OFF_BIT]  = bus_wdata[PWR_OFF_BIT];
            pwr_v[PWR_CLR_BIT]  = bus_wdata[PWR_CLR_BIT];
            pwr_v[PWR_STAT_BIT] = rst_q.pwr[PWR_STAT_BIT];
            if (pwr_v[PWR_CLR_BIT]) begin
                pwr_v = pwr_v & (8'h01 << PWR_OFF_BIT);
            end
            rst_d.pwr = pwr_v;
            rst_d.sd  = pwr_v[PWR_OFF_BIT];
        end

        if (pf_s && !rst_q.pf_prev) begin
            rst_d.pwr[PWR_STAT_BIT] = rst_q.cfg[CFG_EN_BIT];
        end else if (!pf_s && rst_q.pf_prev) begin
            rst_d.pwr[PWR_STAT_BIT] = 1'b0;
        end

        if (wr_hit[RG_SYS] && bus_wdata[SYS_GO_BIT]) begin
            keep_d.sys = SYS_RST_STATUS;
            rst_d.rr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= '0;
        else        rst_q <= rst_d;
    end

    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    assign rd_vals[RG_CFG]  = DATA_W'(rst_q.cfg);
    assign rd_vals[RG_FUNC] = DATA_W'(rst_q.func);
    assign rd_vals[RG_PWR]  = DATA_W'(rst_q.pwr);
    assign rd_vals[RG_SCR]  = DATA_W'(keep_q.scr);
    assign rd_vals[RG_MDM]  = DATA_W'(rst_q.mdm);
    assign rd_vals[RG_LED]  = DATA_W'(keep_q.led);
    assign rd_vals[RG_SYS]  = DATA_W'(keep_q.sys);

    pfa_rdmux #(.N(NREG), .W(DATA_W)) u_mux (
        .hit(rd_hit), .vals(rd_vals), .rdata(bus_rdata)
    );

    assign cfg_en_w     = rst_q.cfg[CFG_EN_BIT];
    assign sys_view     = keep_q.sys;
    assign pf_irq       = rst_q.pwr[PWR_STAT_BIT] & cfg_en_w;
    assign tc_pulse     = rst_q.tc;
    assign shutdown_req = rst_q.sd;
    assign reset_req    = rst_q.rr;
endmodule

// File: rtl/pfa_checker.sv
module pfa_checker
    import pfa_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  bus_sel,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_size,
    input logic [1:0]  bus_off,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        pf_irq,
    input logic        tc_pulse,
    input logic        shutdown_req,
    input logic        reset_req,
    input logic        cfg_en,
    input logic [7:0]  sys_val
);
    logic func_tc_wr, pwr_off_wr, sys_go_wr, cfg_bad_rd;

    assign func_tc_wr = bus_wr && bus_sel[RG_FUNC] && bus_size == SZ_BYTE && bus_wdata[1];
    assign pwr_off_wr = bus_wr && bus_sel[RG_PWR] && bus_size == SZ_BYTE && bus_wdata[0];
    assign sys_go_wr  = bus_wr && bus_sel[RG_SYS] && bus_size == SZ_WORD
                        && bus_off == 2'd0 && bus_wdata[0];
    assign cfg_bad_rd = bus_rd && bus_sel == 7'b0000001 && bus_size != SZ_BYTE;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pf_irq |-> cfg_en); // R1
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(func_tc_wr)); // R5
    AST_SD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(pwr_off_wr)); // R4
    AST_RR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(sys_go_wr)); // R6
    AST_SYS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_go_wr |=> (sys_val == 8'h02)); // R6
    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_go_wr |=> $stable(sys_val)); // R6
    AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad_rd |-> (bus_rdata == 32'd0)); // R8
endmodule

bind pwrfail_aux_regs pfa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pf_irq(pf_irq),
    .tc_pulse(tc_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req),
    .cfg_en(cfg_en_w), .sys_val(sys_view)
);

// File: tb/tb_pwrfail_aux_regs.sv
module tb_pwrfail_aux_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail_in = 1'b0;
    logic [6:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [1:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pf_irq, tc_pulse, shutdown_req, reset_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrfail_aux_regs dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail_in(pwr_fail_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pf_irq(pf_irq),
        .tc_pulse(tc_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    // behavioural reference model
    logic [7:0] m_cfg = 0, m_func = 0, m_pwr = 0, m_mdm = 0;
    logic       m_tc = 0, m_sd = 0, m_rr = 0;
    bit         pf_hist[$] = '{0, 0, 0, 0};

    function automatic bit legal(int idx, logic [1:0] sz, logic [1:0] off);
        int need = (idx == 5) ? 1 : (idx == 6) ? 2 : 0;
        if (int'(sz) != need) return 0;
        if (idx >= 5 && off != 2'd0) return 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0; m_func = 0; m_pwr = 0; m_mdm = 0;
            m_tc = 0; m_sd = 0; m_rr = 0;
            pf_hist = '{0, 0, 0, 0};
        end else begin
            logic [7:0] nc, nf, np, nm;
            bit ntc, nsd, nrr;
            nc = m_cfg; nf = m_func; np = m_pwr; nm = m_mdm;
            ntc = 0; nsd = 0; nrr = 0;
            if (bus_wr) begin
                if (bus_sel[0] && legal(0, bus_size, bus_off)) nc = bus_wdata[7:0];
                if (bus_sel[4] && legal(4, bus_size, bus_off)) nm = bus_wdata[7:0];
                if (bus_sel[1] && legal(1, bus_size, bus_off)) begin
                    nf = bus_wdata[7:0] & 8'hFD;
                    ntc = bus_wdata[1];
                end
                if (bus_sel[2] && legal(2, bus_size, bus_off)) begin
                    if (bus_wdata[1]) np = {7'd0, bus_wdata[0]};
                    else              np = {2'b00, m_pwr[5], 4'd0, bus_wdata[0]};
                    nsd = bus_wdata[0];
                end
                if (bus_sel[6] && legal(6, bus_size, bus_off) && bus_wdata[0]) nrr = 1;
            end
            pf_hist.push_front(pwr_fail_in);
            if (pf_hist[2] && !pf_hist[3])      np[5] = m_cfg[3];
            else if (!pf_hist[2] && pf_hist[3]) np[5] = 1'b0;
            void'(pf_hist.pop_back());
            m_cfg = nc; m_func = nf; m_pwr = np; m_mdm = nm;
            m_tc = ntc; m_sd = nsd; m_rr = nrr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare outputs with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 irq", {31'd0, pf_irq}, {31'd0, m_pwr[5] & m_cfg[3]});
            chk("R5 tc", {31'd0, tc_pulse}, {31'd0, m_tc});
            chk("R4 shutdown", {31'd0, shutdown_req}, {31'd0, m_sd});
            chk("R6 reset_req", {31'd0, reset_req}, {31'd0, m_rr});
        end
    end

    task automatic wr(input int idx, input logic [1:0] sz, input logic [1:0] off,
                      input logic [31:0] d);
        @(negedge clk);
        bus_sel = 7'(1 << idx); bus_size = sz; bus_off = off;
        bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = '0;
    endtask

    task automatic rd(input string req, input int idx, input logic [1:0] sz,
                      input logic [1:0] off, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 7'(1 << idx); bus_size = sz; bus_off = off; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        bus_rd = 1'b0; bus_sel = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R7 reset state of the cleared registers
        rd("R7 cfg", 0, 2'd0, 2'd0, 32'h0);
        rd("R7 func", 1, 2'd0, 2'd0, 32'h0);
        rd("R7 pwr", 2, 2'd0, 2'd0, 32'h0);
        rd("R7 mdm", 4, 2'd0, 2'd0, 32'h0);
        // R9 scratch readback
        wr(3, 2'd0, 2'd0, 32'h0000_00A5);
        wr(4, 2'd0, 2'd0, 32'h0000_003C);
        wr(5, 2'd1, 2'd0, 32'h0000_1234);
        rd("R9 diag", 3, 2'd0, 2'd0, 32'hA5);
        rd("R9 modem", 4, 2'd0, 2'd0, 32'h3C);
        rd("R9 led", 5, 2'd1, 2'd0, 32'h1234);
        // R6 system control
        wr(6, 2'd2, 2'd0, 32'h0000_0001);
        rd("R6 sys status", 6, 2'd2, 2'd0, 32'h02);
        wr(6, 2'd2, 2'd0, 32'hFFFF_FFFE);
        rd("R6 sys unchanged", 6, 2'd2, 2'd0, 32'h02);
        // R8 size and offset mismatches
        rd("R8 sys offset", 6, 2'd2, 2'd1, 32'h0);
        wr(0, 2'd1, 2'd0, 32'h0000_0008);
        rd("R8 cfg half write ignored", 0, 2'd0, 2'd0, 32'h0);
        rd("R8 cfg word read", 0, 2'd2, 2'd0, 32'h0);
        wr(5, 2'd0, 2'd0, 32'h0000_00FF);
        wr(5, 2'd1, 2'd2, 32'h0000_5555);
        rd("R8 led ignored", 5, 2'd1, 2'd0, 32'h1234);
        wr(6, 2'd2, 2'd3, 32'h1);
        idle(1);
        // R5 terminal count
        wr(1, 2'd0, 2'd0, 32'h0000_00FF);
        rd("R5 func readback", 1, 2'd0, 2'd0, 32'hFD);
        wr(1, 2'd0, 2'd0, 32'h0000_0040);
        rd("R5 func no tc", 1, 2'd0, 2'd0, 32'h40);
        // R2 / R1 power fail
        wr(0, 2'd0, 2'd0, 32'h08);
        @(negedge clk); pwr_fail_in = 1'b1;
        idle(4);
        chk("R1 irq on", {31'd0, pf_irq}, 32'd1);
        rd("R2 status set", 2, 2'd0, 2'd0, 32'h20);
        wr(2, 2'd0, 2'd0, 32'h02);
        rd("R3 clear", 2, 2'd0, 2'd0, 32'h00);
        idle(4);
        rd("R2 sticky to events", 2, 2'd0, 2'd0, 32'h00);
        @(negedge clk); pwr_fail_in = 1'b0;
        idle(4);
        wr(0, 2'd0, 2'd0, 32'h00);
        @(negedge clk); pwr_fail_in = 1'b1;
        idle(4);
        rd("R2 rise while disabled", 2, 2'd0, 2'd0, 32'h00);
        @(negedge clk); pwr_fail_in = 1'b0;
        idle(4);
        wr(0, 2'd0, 2'd0, 32'h08);
        @(negedge clk); pwr_fail_in = 1'b1;
        idle(4);
        wr(0, 2'd0, 2'd0, 32'h00);
        chk("R1 irq gated", {31'd0, pf_irq}, 32'd0);
        rd("R1 status kept", 2, 2'd0, 2'd0, 32'h20);
        wr(2, 2'd0, 2'd0, 32'h01);
        rd("R3 keep status", 2, 2'd0, 2'd0, 32'h21);
        wr(2, 2'd0, 2'd0, 32'hFC);
        rd("R3 only low bits", 2, 2'd0, 2'd0, 32'h20);
        @(negedge clk); pwr_fail_in = 1'b0;
        idle(4);
        rd("R2 fall clears", 2, 2'd0, 2'd0, 32'h00);
        wr(2, 2'd0, 2'd0, 32'h03);
        rd("R3 clear with off", 2, 2'd0, 2'd0, 32'h01);
        // R7 selective reset
        wr(0, 2'd0, 2'd0, 32'h5A);
        wr(1, 2'd0, 2'd0, 32'h81);
        wr(4, 2'd0, 2'd0, 32'h77);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd("R7 cfg cleared", 0, 2'd0, 2'd0, 32'h0);
        rd("R7 func cleared", 1, 2'd0, 2'd0, 32'h0);
        rd("R7 pwr cleared", 2, 2'd0, 2'd0, 32'h0);
        rd("R7 mdm cleared", 4, 2'd0, 2'd0, 32'h0);
        rd("R7 diag kept", 3, 2'd0, 2'd0, 32'hA5);
        rd("R7 led kept", 5, 2'd1, 2'd0, 32'h1234);
        rd("R7 sys kept", 6, 2'd2, 2'd0, 32'h02);
        idle(2);
        finish_run();
    end
endmodule